// File: doc/BRIEF.md
# Quadword Scratchpad with Sub-word Access

This block is the private working memory of one processing element. Its storage array moves only whole 128-bit quadwords, and every access takes a fixed number of cycles. There is no cache, no tag and no miss path. The element sends requests through a single port carrying a byte address, a size code, a write enable and write data. Load results come back on a response port one cycle after the request is accepted.

Narrower accesses are built on top of the quadword array.

- A byte, halfword or word load reads the containing quadword. It then pulls the addressed lanes out and returns them zero-extended.
- A byte, halfword or word store reads the containing quadword, merges the new bytes in, and writes the full quadword back on the next cycle. A busy flag holds off new requests during that second cycle.
- A narrow access that would run past the end of its quadword is rejected with an error pulse.

The number of entries is a parameter. A full-size build uses 16384 entries (256 KiB). The default is kept small so that simulation stays light.

Top module: `qw_scratchpad`

## Requirements
- R1: While rst_ni is low and on the first cycle after it rises, rsp_valid_o, busy_o and err_o are all 0.
- R2: A quadword store (size code 3) writes all 16 bytes of entry addr[ADDR_W-1:4]. A quadword load returns that whole entry. For size 3 the low four address bits are ignored.
- R3: An accepted load with no error raises rsp_valid_o for exactly one cycle, in the cycle after acceptance, with its data on rsp_rdata_o. A store never raises rsp_valid_o.
- R4: Size codes are 0 byte, 1 halfword (2 bytes), 2 word (4 bytes) and 3 quadword. Byte offset k = addr[3:0] names lane k, which sits at bits [127-8k:120-8k], so lane 0 is the most significant byte.
- R5: A load of n < 16 bytes at offset k returns lanes k..k+n-1 in the low 8n bits of rsp_rdata_o. Lane k is the most significant of these, and all higher bits are 0.
- R6: A store of n < 16 bytes at offset k takes the low 8n bits of req_wdata_i. Their most significant byte goes to lane k and the rest follow in order. The other 16-n lanes and the high bits of req_wdata_i have no effect.
- R7: After a narrow store is accepted, busy_o is 1 for exactly the next cycle. A request presented while busy_o is 1 is ignored: it writes nothing and returns no response.
- R8: A narrow access with k + n > 16 raises err_o for one cycle, in the cycle after it is presented. It writes no memory, sets no busy and gives no response.
- R9: A quadword store accepted in one cycle is visible to a load accepted in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | ADDR_W | Byte address; bits [3:0] are the lane offset |
| req_size_i | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 quad) |
| req_we_i | input | 1 | 1 for store, 0 for load |
| req_wdata_i | input | 128 | Store data; narrow stores use the low bytes |
| busy_o | output | 1 | Merge write-back cycle in progress; requests ignored |
| rsp_valid_o | output | 1 | Load data valid |
| rsp_rdata_o | output | 128 | Load data, zero-extended for narrow loads |
| err_o | output | 1 | Previous request did not fit inside its quadword |

## Verification
The bench targets the lane order at both ends of a quadword: offsets 0 and 15, and a word at offset 1 that is not naturally aligned. A design with the lane order reversed, or that extracts from the wrong end, returns a different byte. Narrow stores are driven with junk in the upper write-data bits, and then the whole quadword is read back. A merge mask that is too wide, or placed wrongly, corrupts neighbouring lanes. Requests are presented during the busy cycle, and stores that overrun by a single byte are sent. A design that accepts work while busy, or that writes on an error, leaves changed memory that a later quadword load exposes. A load is also placed directly after a quadword store to catch a stale read.

// File: rtl/qw_pkg.sv
`timescale 1ns/1ps
package qw_pkg;
  localparam int unsigned QW_BITS  = 128;
  localparam int unsigned QW_BYTES = QW_BITS / 8;
  localparam int unsigned OFF_W    = $clog2(QW_BYTES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_QUAD = 2'd3
  } size_e;

  function automatic logic [OFF_W:0] size_bytes(size_e s);
    return (OFF_W+1)'(1) << s;
  endfunction
endpackage

// File: rtl/qw_ram.sv
`timescale 1ns/1ps
module qw_ram #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned WIDTH = 128,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [WIDTH-1:0] rd_data_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [WIDTH-1:0] wr_data_i
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  // read-before-write on the same edge is never needed: busy blocks it
  always_ff @(posedge clk_i) begin
    if (rd_en_i) rd_data_o <= mem_q[rd_idx_i];
  end
endmodule

// File: rtl/qw_lane_extract.sv
`timescale 1ns/1ps
module qw_lane_extract
  import qw_pkg::*;
(
  input  logic [QW_BITS-1:0] qw_i,
  input  logic [OFF_W-1:0]   off_i,
  input  size_e              size_i,
  output logic [QW_BITS-1:0] data_o
);
  logic [QW_BITS-1:0] aligned;

  // move lane off_i to the top, then take the top n bytes
  assign aligned = qw_i << {off_i, 3'b000};

  always_comb begin
    unique case (size_i)
      SZ_BYTE: data_o = {{(QW_BITS-8){1'b0}},  aligned[QW_BITS-1 -: 8]};
      SZ_HALF: data_o = {{(QW_BITS-16){1'b0}}, aligned[QW_BITS-1 -: 16]};
      SZ_WORD: data_o = {{(QW_BITS-32){1'b0}}, aligned[QW_BITS-1 -: 32]};
      default: data_o = qw_i;
    endcase
  end
endmodule

// File: rtl/qw_lane_merge.sv
`timescale 1ns/1ps
module qw_lane_merge
  import qw_pkg::*;
(
  input  logic [QW_BITS-1:0] old_i,
  input  logic [QW_BITS-1:0] wdata_i,
  input  logic [OFF_W-1:0]   off_i,
  input  size_e              size_i,
  output logic [QW_BITS-1:0] data_o
);
  logic [OFF_W:0] nbytes;
  logic [OFF_W:0] first;
  logic [OFF_W:0] last_excl;

  assign nbytes    = size_bytes(size_i);
  assign first     = (size_i == SZ_QUAD) ? '0 : {1'b0, off_i};
  assign last_excl = first + nbytes;

  for (genvar lane = 0; lane < QW_BYTES; lane++) begin : g_lane
    logic           hit;
    logic [OFF_W:0] src;
    assign hit = ((OFF_W+1)'(lane) >= first) && ((OFF_W+1)'(lane) < last_excl);
    // lane 'first' takes the most significant byte of the low n bytes
    assign src = last_excl - (OFF_W+1)'(1) - (OFF_W+1)'(lane);
    assign data_o[QW_BITS-1-8*lane -: 8] =
      hit ? wdata_i[8*src[OFF_W-1:0] +: 8] : old_i[QW_BITS-1-8*lane -: 8];
  end
endmodule

// File: rtl/qw_scratchpad.sv
`timescale 1ns/1ps
module qw_scratchpad
  import qw_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned ADDR_W = IDX_W + OFF_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [1:0]          req_size_i,
  input  logic                req_we_i,
  input  logic [QW_BITS-1:0]  req_wdata_i,
  output logic                busy_o,
  output logic                rsp_valid_o,
  output logic [QW_BITS-1:0]  rsp_rdata_o,
  output logic                err_o
);
  size_e             req_size;
  logic [OFF_W-1:0]  req_off;
  logic [IDX_W-1:0]  req_idx;
  logic [OFF_W:0]    req_end;
  logic              is_quad, fits, accept;
  logic              ld_go, rmw_go, qst_go, bad_go;

  logic              ld_q, rmw_q, err_q;
  logic [OFF_W-1:0]  off_q;
  size_e             size_q;
  logic [IDX_W-1:0]  idx_q;
  logic [QW_BITS-1:0] wdata_q;

  logic              rd_en, wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [QW_BITS-1:0] rd_qw, wr_qw, merged_qw, extract_qw;

  assign req_size = size_e'(req_size_i);
  assign req_off  = req_addr_i[OFF_W-1:0];
  assign req_idx  = req_addr_i[ADDR_W-1:OFF_W];
  assign req_end  = {1'b0, req_off} + size_bytes(req_size);
  assign is_quad  = (req_size == SZ_QUAD);
  assign fits     = is_quad || (req_end <= (OFF_W+1)'(QW_BYTES));
  assign accept   = req_valid_i && !rmw_q;

  assign bad_go = accept && !fits;
  assign ld_go  = accept && fits && !req_we_i;
  assign rmw_go = accept && fits && req_we_i && !is_quad;
  assign qst_go = accept && req_we_i && is_quad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_q    <= 1'b0;
      rmw_q   <= 1'b0;
      err_q   <= 1'b0;
      off_q   <= '0;
      size_q  <= SZ_BYTE;
      idx_q   <= '0;
      wdata_q <= '0;
    end else begin
      ld_q  <= ld_go;
      rmw_q <= rmw_go;
      err_q <= bad_go;
      if (ld_go || rmw_go) begin
        off_q   <= req_off;
        size_q  <= req_size;
        idx_q   <= req_idx;
        wdata_q <= req_wdata_i;
      end
    end
  end

  // quad store and merge write-back never coincide: busy blocks accept
  assign rd_en  = ld_go || rmw_go;
  assign wr_en  = qst_go || rmw_q;
  assign wr_idx = rmw_q ? idx_q : req_idx;
  assign wr_qw  = rmw_q ? merged_qw : req_wdata_i;

  qw_ram #(.DEPTH(DEPTH), .WIDTH(QW_BITS)) u_ram (
    .clk_i     (clk_i),
    .rd_en_i   (rd_en),
    .rd_idx_i  (req_idx),
    .rd_data_o (rd_qw),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_qw)
  );

  qw_lane_extract u_extract (
    .qw_i   (rd_qw),
    .off_i  (off_q),
    .size_i (size_q),
    .data_o (extract_qw)
  );

  qw_lane_merge u_merge (
    .old_i   (rd_qw),
    .wdata_i (wdata_q),
    .off_i   (off_q),
    .size_i  (size_q),
    .data_o  (merged_qw)
  );

  assign busy_o      = rmw_q;
  assign rsp_valid_o = ld_q;
  assign rsp_rdata_o = extract_qw;
  assign err_o       = err_q;
endmodule

// File: rtl/qw_scratchpad_checker.sv
`timescale 1ns/1ps
module qw_scratchpad_checker #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [1:0]        req_size_i,
  input logic              req_we_i,
  input logic              busy_o,
  input logic              rsp_valid_o,
  input logic [127:0]      rsp_rdata_o,
  input logic              err_o
);
  logic acc, fit, narrow;
  assign acc    = req_valid_i && !busy_o;
  assign narrow = (req_size_i != 2'd3);
  assign fit    = !narrow || (({1'b0, req_addr_i[3:0]} + (5'd1 << req_size_i)) <= 5'd16);

  assert_rsp_after_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !req_we_i && fit |=> rsp_valid_o && !err_o);

  assert_rsp_has_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(acc && !req_we_i));

  assert_store_no_rsp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && req_we_i |=> !rsp_valid_o);

  assert_byte_zero_ext_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !req_we_i && req_size_i == 2'd0 |=> rsp_rdata_o[127:8] == '0);

  assert_busy_follows_merge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && req_we_i && narrow && fit |=> busy_o);

  assert_busy_one_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o);

  assert_overrun_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !fit |=> err_o && !rsp_valid_o && !busy_o);

  assert_rsp_busy_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_valid_o && busy_o));
endmodule

bind qw_scratchpad qw_scratchpad_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_addr_i  (req_addr_i),
  .req_size_i  (req_size_i),
  .req_we_i    (req_we_i),
  .busy_o      (busy_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_rdata_o (rsp_rdata_o),
  .err_o       (err_o)
);

// File: tb/qw_scratchpad_bench.sv
`timescale 1ns/1ps
module qw_scratchpad_bench;
  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH) + 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic          req_we = 1'b0;
  logic [127:0]  req_wdata = '0;
  logic          busy, rsp_valid, err;
  logic [127:0]  rsp_rdata;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  logic [127:0] mdl [DEPTH];

  always #2.5 clk = ~clk;

  qw_scratchpad #(.DEPTH(DEPTH)) u_qw_scratchpad (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_addr_i  (req_addr),
    .req_size_i  (req_size),
    .req_we_i    (req_we),
    .req_wdata_i (req_wdata),
    .busy_o      (busy),
    .rsp_valid_o (rsp_valid),
    .rsp_rdata_o (rsp_rdata),
    .err_o       (err)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] expect_load(input logic [127:0] qw, input int off, input int sz);
    logic [127:0] v = '0;
    int n = 1 << sz;
    if (sz == 3) return qw;
    for (int j = 0; j < n; j++) v = (v << 8) | 128'(qw[127-8*(off+j) -: 8]);
    return v;
  endfunction

  task automatic model_store(input logic [AW-1:0] a, input int sz, input logic [127:0] wd);
    int idx = int'(a[AW-1:4]);
    int off = int'(a[3:0]);
    int n = 1 << sz;
    if (sz == 3) mdl[idx] = wd;
    else for (int j = 0; j < n; j++) mdl[idx][127-8*(off+j) -: 8] = wd[8*(n-1-j) +: 8];
  endtask

  // present for one edge, return at the negedge after it
  task automatic issue(input logic [AW-1:0] a, input int sz, input bit we, input logic [127:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = 2'(sz); req_we = we; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_load(input logic [AW-1:0] a, input int sz, input string tag);
    logic [127:0] e;
    e = expect_load(mdl[int'(a[AW-1:4])], int'(a[3:0]), sz);
    issue(a, sz, 1'b0, '0);
    chk(rsp_valid === 1'b1, {tag, " rsp_valid"}, 128'(rsp_valid), 128'(1));
    chk(rsp_rdata === e, {tag, " data"}, rsp_rdata, e);
  endtask

  task automatic do_store(input logic [AW-1:0] a, input int sz, input logic [127:0] wd, input string tag);
    issue(a, sz, 1'b1, wd);
    model_store(a, sz, wd);
    chk(rsp_valid === 1'b0, {tag, " store gives no rsp R3"}, 128'(rsp_valid), 128'(0));
    if (sz != 3) begin
      chk(busy === 1'b1, {tag, " busy after merge store R7"}, 128'(busy), 128'(1));
      @(negedge clk);
      chk(busy === 1'b0, {tag, " busy drops R7"}, 128'(busy), 128'(0));
    end
  endtask

  task automatic t_reset();
    #1;
    chk(rsp_valid === 1'b0 && busy === 1'b0 && err === 1'b0, "R1 in reset",
        128'({rsp_valid, busy, err}), 128'(0));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid === 1'b0 && busy === 1'b0 && err === 1'b0, "R1 after release",
        128'({rsp_valid, busy, err}), 128'(0));
  endtask

  task automatic t_quad();
    do_store(AW'('h35), 3, 128'h00112233_44556677_8899AABB_CCDDEEFF, "R2 quad store idx3");
    do_load(AW'('h3A), 3, "R2 quad load idx3 low bits ignored");
    do_store(AW'('h50), 3, 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F, "R2 quad store idx5");
    do_load(AW'('h5F), 3, "R2 quad load idx5");
  endtask

  task automatic t_subload();
    do_load(AW'('h30), 0, "R4 byte lane 0");
    do_load(AW'('h37), 0, "R4 byte lane 7");
    do_load(AW'('h3F), 0, "R5 byte lane 15");
    do_load(AW'('h3E), 1, "R5 half at 14");
    do_load(AW'('h33), 1, "R5 half at 3");
    do_load(AW'('h3C), 2, "R5 word at 12");
    do_load(AW'('h31), 2, "R5 word at 1");
  endtask

  task automatic t_substore();
    do_store(AW'('h35), 0, {120'hDEAD_BEEF_0000_1111_2222_3333_4444_55, 8'hAB}, "R6 byte at 5");
    do_load(AW'('h30), 3, "R6 quad after byte store");
    do_store(AW'('h3E), 1, {112'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 16'h1234}, "R6 half at 14");
    do_store(AW'('h30), 2, {96'hA5A5_A5A5_A5A5_A5A5_A5A5_A5A5, 32'h89ABCDEF}, "R6 word at 0");
    do_load(AW'('h30), 3, "R6 quad after half/word stores");
    do_load(AW'('h35), 0, "R6 byte readback");
  endtask

  task automatic t_ignored();
    // quad store presented during busy must not land
    @(negedge clk);
    req_valid = 1'b1; req_addr = AW'('h50); req_size = 2'd0; req_we = 1'b1; req_wdata = 128'h5A;
    @(negedge clk);
    model_store(AW'('h50), 0, 128'h5A);
    chk(busy === 1'b1, "R7 busy window", 128'(busy), 128'(1));
    req_addr = AW'('h50); req_size = 2'd3; req_wdata = '1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b0 && rsp_valid === 1'b0, "R7 blocked store no effect",
        128'({busy, rsp_valid}), 128'(0));
    do_load(AW'('h50), 3, "R7 memory after blocked store");
    // load presented during busy must not answer
    @(negedge clk);
    req_valid = 1'b1; req_addr = AW'('h51); req_size = 2'd0; req_we = 1'b1; req_wdata = 128'hC3;
    @(negedge clk);
    model_store(AW'('h51), 0, 128'hC3);
    req_we = 1'b0; req_size = 2'd3;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b0, "R7 blocked load no rsp", 128'(rsp_valid), 128'(0));
    do_load(AW'('h50), 3, "R7 merge after blocked load");
  endtask

  task automatic t_error();
    issue(AW'('h3E), 2, 1'b1, 128'hFFFFFFFF);
    chk(err === 1'b1 && busy === 1'b0 && rsp_valid === 1'b0, "R8 word store at 14",
        128'({err, busy, rsp_valid}), 128'(4));
    @(negedge clk);
    chk(err === 1'b0, "R8 err one cycle", 128'(err), 128'(0));
    issue(AW'('h3F), 1, 1'b0, '0);
    chk(err === 1'b1 && rsp_valid === 1'b0, "R8 half load at 15",
        128'({err, rsp_valid}), 128'(2));
    issue(AW'('h3D), 2, 1'b1, 128'h0);
    chk(err === 1'b1 && busy === 1'b0, "R8 word store at 13", 128'({err, busy}), 128'(2));
    do_load(AW'('h30), 3, "R8 memory unchanged");
  endtask

  task automatic t_b2b();
    logic [127:0] v = 128'hCAFEF00D_01234567_89ABCDEF_76543210;
    @(negedge clk);
    req_valid = 1'b1; req_addr = AW'('h70); req_size = 2'd3; req_we = 1'b1; req_wdata = v;
    @(negedge clk);
    model_store(AW'('h70), 3, v);
    chk(rsp_valid === 1'b0, "R9 no rsp for store", 128'(rsp_valid), 128'(0));
    req_we = 1'b0; req_addr = AW'('h74); req_size = 2'd2;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1, "R9 load rsp", 128'(rsp_valid), 128'(1));
    chk(rsp_rdata === expect_load(v, 4, 2), "R9 fresh data", rsp_rdata, expect_load(v, 4, 2));
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R3 rsp single pulse", 128'(rsp_valid), 128'(0));
  endtask

  initial begin
    t_reset();
    t_quad();
    t_subload();
    t_substore();
    t_ignored();
    t_error();
    t_b2b();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule